// File: doc/BRIEF.md
# CPU-to-VME Master Address Mapper

This block sits between a 32-bit CPU bus and a VME master interface. It looks at each CPU bus cycle and decides where it goes. The possible targets are local DRAM, the reserved on-board device area, or one of three VME windows: A32 extended, A24 standard and A16 short I/O. For a VME target it also produces the 6-bit address-modifier code, the transfer width and the address to drive on the backplane. Addresses that fall into the unmapped gap produce a decode error instead of a bus request.

The decoded request comes out of a register stage one clock after the CPU request is accepted. The CPU side supplies a registered request: address, read/write and valid. The top of local DRAM is set by a size configuration input. Everything at or above that size, up to the end of the A32 window, goes to the VME bus with an unchanged address. A mode bit switches the A32 and A24 data windows from user to supervisor address modifiers. Both configuration values are taken in only on clocks with no request present, so a decode never sees a boundary that is half updated.

Top module: `vme_map_top`

## Requirements
- R1: An address below the current DRAM size gives target 0 (DRAM), with out_vme_req 0, out_decode_err 0, out_am 0, out_width 2'b00 and out_vme_addr 0.
- R2: An address from the DRAM size through 0xEFFFFFFF gives target 2 (A32), width 2'b10 (D32), out_vme_addr equal to the CPU address, and out_vme_req 1. The AM is 0x09 in user mode.
- R3: An address in 0xF0000000..0xF0FFFFFF gives target 3 (A24), width 2'b01 (D16), out_vme_addr equal to the low 24 bits of the CPU address with the upper bits zero, and out_vme_req 1. The AM is 0x39 in user mode.
- R4: An address in 0xFFFF0000..0xFFFFFFFF gives target 4 (A16), AM 0x2D in either mode, width 2'b01, out_vme_addr equal to the low 16 bits with the upper bits zero, and out_vme_req 1.
- R5: An address in 0xFFF00000..0xFFFEFFFF gives target 1 (on-board I/O), with out_vme_req 0, out_decode_err 0, out_am 0, out_width 2'b00 and out_vme_addr 0.
- R6: An address in 0xF1000000..0xFFEFFFFF gives target 5 (none), with out_decode_err 1, out_vme_req 0, out_am 0, out_width 2'b00 and out_vme_addr 0.
- R7: With cfg_supervisor taken in as 1, the A32 window uses AM 0x0D and the A24 window uses AM 0x3D. The A16 AM does not change.
- R8: out_valid is 1 exactly on the clock after one in which req_valid was 1, and 0 otherwise, including after reset. out_write repeats the request's write bit. out_vme_req and out_decode_err are 0 whenever out_valid is 0.
- R9: The DRAM size resets to 4 MB (0x00400000). A cfg_dram_size value is taken in only if it is a power of two from 0x00400000 to 0x10000000. Any other value leaves the size unchanged.
- R10: cfg_dram_size and cfg_supervisor are taken in only at a clock edge where req_valid is 0. A change made while a request is present has no effect on that request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | CPU request present this cycle |
| req_addr | input | 32 | CPU address |
| req_write | input | 1 | 1 for write, 0 for read |
| cfg_dram_size | input | 32 | Proposed DRAM size in bytes |
| cfg_supervisor | input | 1 | 1 selects supervisor AMs for A32/A24 |
| out_valid | output | 1 | Decoded request present |
| out_write | output | 1 | Write bit of the decoded request |
| out_target | output | 3 | 0 DRAM, 1 I/O, 2 A32, 3 A24, 4 A16, 5 none |
| out_am | output | 6 | VME address-modifier code |
| out_width | output | 2 | 00 D8, 01 D16, 10 D32 |
| out_vme_addr | output | 32 | Translated VME address |
| out_vme_req | output | 1 | Decoded request goes to the VME bus |
| out_decode_err | output | 1 | Address reaches no window |

## Verification
Addresses are chosen on both sides of every window edge: the last DRAM byte and the first A32 byte, the top of A32, both ends of A24, the gap, the on-board I/O area and A16. This separates an off-by-one boundary from a wrong window order. The same addresses are then repeated in supervisor mode and after legal size changes to 16 MB and 256 MB. The DRAM/A32 edge thus follows the size register, while the fixed windows stay where they are. Illegal sizes (not a power of two, too small, too large) and a size change made while requests are back to back show whether the register rejects values and waits for an idle clock.

// File: rtl/vme_map_pkg.sv
package vme_map_pkg;

  typedef enum logic [2:0] {
    TGT_DRAM     = 3'd0,
    TGT_LOCAL_IO = 3'd1,
    TGT_A32      = 3'd2,
    TGT_A24      = 3'd3,
    TGT_A16      = 3'd4,
    TGT_NONE     = 3'd5
  } target_e;

  typedef enum logic [1:0] {
    WID_D8  = 2'b00,
    WID_D16 = 2'b01,
    WID_D32 = 2'b10
  } width_e;

  localparam logic [5:0] AM_EXT_USR_DATA = 6'h09;
  localparam logic [5:0] AM_EXT_SUP_DATA = 6'h0D;
  localparam logic [5:0] AM_STD_USR_DATA = 6'h39;
  localparam logic [5:0] AM_STD_SUP_DATA = 6'h3D;
  localparam logic [5:0] AM_SHORT_SUP_IO = 6'h2D;

  typedef struct packed {
    logic        valid;
    logic        write;
    target_e     target;
    logic [5:0]  am;
    width_e      width;
    logic [31:0] vaddr;
    logic        vme_req;
    logic        dec_err;
  } map_result_t;

  // Keep the low 'bits' bits of an address, clear the rest.
  function automatic logic [31:0] trunc_addr(input logic [31:0] a, input int unsigned bits);
    logic [32:0] mask;
    mask = (33'd1 << bits) - 33'd1;
    return a & mask[31:0];
  endfunction

  // A power of two between 2**lo and 2**hi inclusive.
  function automatic logic size_is_legal(input logic [31:0] s, input int unsigned lo,
                                         input int unsigned hi);
    logic [32:0] lo_v;
    logic [32:0] hi_v;
    lo_v = 33'd1 << lo;
    hi_v = 33'd1 << hi;
    return ($countones(s) == 1) && ({1'b0, s} >= lo_v) && ({1'b0, s} <= hi_v);
  endfunction

  function automatic logic [5:0] am_for(input target_e t, input logic sup);
    case (t)
      TGT_A32: return sup ? AM_EXT_SUP_DATA : AM_EXT_USR_DATA;
      TGT_A24: return sup ? AM_STD_SUP_DATA : AM_STD_USR_DATA;
      TGT_A16: return AM_SHORT_SUP_IO;
      default: return 6'h00;
    endcase
  endfunction

  function automatic logic is_vme_target(input target_e t);
    return (t == TGT_A32) || (t == TGT_A24) || (t == TGT_A16);
  endfunction

endpackage

// File: rtl/vme_map_cfg.sv
module vme_map_cfg
  import vme_map_pkg::*;
#(
  parameter int unsigned MIN_LOG2 = 22,
  parameter int unsigned MAX_LOG2 = 28
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        req_pending,
  input  logic [31:0] cfg_size,
  input  logic        cfg_sup,
  output logic [31:0] dram_size,
  output logic        sup_mode,
  output logic        size_accept,
  output logic        mode_accept
);

  localparam logic [31:0] RESET_SIZE = 32'd1 << MIN_LOG2;

  logic size_ok;

  always_comb begin
    size_ok     = size_is_legal(cfg_size, MIN_LOG2, MAX_LOG2);
    mode_accept = !req_pending;
    size_accept = mode_accept && size_ok;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      dram_size <= RESET_SIZE;
      sup_mode  <= 1'b0;
    end else begin
      if (size_accept) dram_size <= cfg_size;
      if (mode_accept) sup_mode  <= cfg_sup;
    end
  end

endmodule

// File: rtl/vme_map_decode.sv
module vme_map_decode
  import vme_map_pkg::*;
#(
  parameter logic [31:0] A32_LAST  = 32'hEFFF_FFFF,
  parameter logic [31:0] A24_BASE  = 32'hF000_0000,
  parameter int unsigned A24_BITS  = 24,
  parameter logic [31:0] IO_BASE   = 32'hFFF0_0000,
  parameter logic [31:0] A16_BASE  = 32'hFFFF_0000,
  parameter int unsigned A16_BITS  = 16
) (
  input  logic        req_valid,
  input  logic        req_write,
  input  logic [31:0] req_addr,
  input  logic [31:0] dram_size,
  input  logic        sup_mode,
  output map_result_t result,
  output logic        hit_dram,
  output logic        hit_a32
);

  localparam int unsigned NFIX = 4;
  localparam logic [31:0] A24_LAST = A24_BASE + ((32'd1 << A24_BITS) - 32'd1);
  localparam logic [31:0] GAP_BASE = A24_LAST + 32'd1;
  localparam logic [31:0] GAP_LAST = IO_BASE - 32'd1;
  localparam logic [31:0] IO_LAST  = A16_BASE - 32'd1;
  localparam logic [31:0] A16_LAST = A16_BASE + ((32'd1 << A16_BITS) - 32'd1);

  localparam logic [31:0] WIN_BASE [NFIX] = '{A24_BASE, GAP_BASE, IO_BASE, A16_BASE};
  localparam logic [31:0] WIN_LAST [NFIX] = '{A24_LAST, GAP_LAST, IO_LAST, A16_LAST};
  localparam target_e     WIN_TGT  [NFIX] = '{TGT_A24, TGT_NONE, TGT_LOCAL_IO, TGT_A16};

  logic [NFIX-1:0] fix_hit;

  for (genvar i = 0; i < NFIX; i++) begin : g_win
    assign fix_hit[i] = (req_addr >= WIN_BASE[i]) && (req_addr <= WIN_LAST[i]);
  end

  target_e tgt;

  always_comb begin
    hit_dram = req_addr < dram_size;
    hit_a32  = !hit_dram && (req_addr <= A32_LAST);
    tgt      = TGT_NONE;
    if (hit_dram) begin
      tgt = TGT_DRAM;
    end else if (hit_a32) begin
      tgt = TGT_A32;
    end else begin
      for (int k = 0; k < NFIX; k++) begin
        if (fix_hit[k]) tgt = WIN_TGT[k];
      end
    end
  end

  always_comb begin
    result         = '0;
    result.valid   = req_valid;
    result.write   = req_write;
    result.target  = tgt;
    result.am      = am_for(tgt, sup_mode);
    result.width   = WID_D8;
    result.vaddr   = '0;
    case (tgt)
      TGT_A32: begin
        result.width = WID_D32;
        result.vaddr = req_addr;
      end
      TGT_A24: begin
        result.width = WID_D16;
        result.vaddr = trunc_addr(req_addr, A24_BITS);
      end
      TGT_A16: begin
        result.width = WID_D16;
        result.vaddr = trunc_addr(req_addr, A16_BITS);
      end
      default: ;
    endcase
    result.vme_req = req_valid && is_vme_target(tgt);
    result.dec_err = req_valid && (tgt == TGT_NONE);
  end

endmodule

// File: rtl/vme_map_outreg.sv
module vme_map_outreg
  import vme_map_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  map_result_t d,
  output map_result_t q
);

  always_ff @(posedge clk) begin
    if (!rst_n) q <= '0;
    else        q <= d;
  end

endmodule

// File: rtl/vme_map_top.sv
module vme_map_top
  import vme_map_pkg::*;
#(
  parameter int unsigned MIN_LOG2 = 22,
  parameter int unsigned MAX_LOG2 = 28,
  parameter logic [31:0] A32_LAST = 32'hEFFF_FFFF,
  parameter logic [31:0] A24_BASE = 32'hF000_0000,
  parameter int unsigned A24_BITS = 24,
  parameter logic [31:0] IO_BASE  = 32'hFFF0_0000,
  parameter logic [31:0] A16_BASE = 32'hFFFF_0000,
  parameter int unsigned A16_BITS = 16
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        req_valid,
  input  logic [31:0] req_addr,
  input  logic        req_write,
  input  logic [31:0] cfg_dram_size,
  input  logic        cfg_supervisor,
  output logic        out_valid,
  output logic        out_write,
  output logic [2:0]  out_target,
  output logic [5:0]  out_am,
  output logic [1:0]  out_width,
  output logic [31:0] out_vme_addr,
  output logic        out_vme_req,
  output logic        out_decode_err
);

  logic [31:0] dram_size;
  logic        sup_mode;
  logic        size_accept;
  logic        mode_accept;
  logic        hit_dram;
  logic        hit_a32;
  map_result_t dec_res;
  map_result_t reg_res;

  vme_map_cfg #(
    .MIN_LOG2(MIN_LOG2),
    .MAX_LOG2(MAX_LOG2)
  ) u_cfg (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_pending(req_valid),
    .cfg_size   (cfg_dram_size),
    .cfg_sup    (cfg_supervisor),
    .dram_size  (dram_size),
    .sup_mode   (sup_mode),
    .size_accept(size_accept),
    .mode_accept(mode_accept)
  );

  vme_map_decode #(
    .A32_LAST(A32_LAST),
    .A24_BASE(A24_BASE),
    .A24_BITS(A24_BITS),
    .IO_BASE (IO_BASE),
    .A16_BASE(A16_BASE),
    .A16_BITS(A16_BITS)
  ) u_dec (
    .req_valid(req_valid),
    .req_write(req_write),
    .req_addr (req_addr),
    .dram_size(dram_size),
    .sup_mode (sup_mode),
    .result   (dec_res),
    .hit_dram (hit_dram),
    .hit_a32  (hit_a32)
  );

  vme_map_outreg u_out (
    .clk  (clk),
    .rst_n(rst_n),
    .d    (dec_res),
    .q    (reg_res)
  );

  always_comb begin
    out_valid      = reg_res.valid;
    out_write      = reg_res.write;
    out_target     = reg_res.target;
    out_am         = reg_res.am;
    out_width      = reg_res.width;
    out_vme_addr   = reg_res.vaddr;
    out_vme_req    = reg_res.vme_req;
    out_decode_err = reg_res.dec_err;
  end

endmodule

// File: rtl/vme_map_checker.sv
module vme_map_checker (
  input logic        clk,
  input logic        rst_n,
  input logic        req_valid,
  input logic        out_valid,
  input logic [2:0]  out_target,
  input logic [5:0]  out_am,
  input logic [1:0]  out_width,
  input logic [31:0] out_vme_addr,
  input logic        out_vme_req,
  input logic        out_decode_err,
  input logic [31:0] dram_size,
  input logic        sup_mode
);

  logic armed;
  always_ff @(posedge clk) begin
    if (!rst_n) armed <= 1'b0;
    else        armed <= 1'b1;
  end

  assert_latency_R8: assert property (@(posedge clk) disable iff (!rst_n)
    armed |-> (out_valid == $past(req_valid)));

  assert_idle_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |-> (!out_vme_req && !out_decode_err));

  assert_dram_local_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_target == 3'd0) |-> !out_vme_req);

  assert_a32_window_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_target == 3'd2) |-> (out_width == 2'b10 && out_vme_addr >= dram_size
                                           && out_vme_addr <= 32'hEFFF_FFFF));

  assert_a24_trunc_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_target == 3'd3) |-> (out_width == 2'b01 && out_vme_addr[31:24] == 8'h00));

  assert_a16_code_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_target == 3'd4) |-> (out_am == 6'h2D && out_vme_addr[31:16] == 16'h0000));

  assert_io_never_vme_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_target == 3'd1) |-> (!out_vme_req && !out_decode_err));

  assert_err_exclusive_R6: assert property (@(posedge clk) disable iff (!rst_n)
    out_decode_err |-> (!out_vme_req && out_target == 3'd5));

  assert_size_legal_R9: assert property (@(posedge clk) disable iff (!rst_n)
    ($countones(dram_size) == 1 && dram_size >= 32'h0040_0000 && dram_size <= 32'h1000_0000));

  assert_cfg_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> ($stable(dram_size) && $stable(sup_mode)));

endmodule

bind vme_map_top vme_map_checker u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .req_valid     (req_valid),
  .out_valid     (out_valid),
  .out_target    (out_target),
  .out_am        (out_am),
  .out_width     (out_width),
  .out_vme_addr  (out_vme_addr),
  .out_vme_req   (out_vme_req),
  .out_decode_err(out_decode_err),
  .dram_size     (dram_size),
  .sup_mode      (sup_mode)
);

// File: tb/vme_map_top_bench.sv
module vme_map_top_bench;

  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic [31:0] req_addr = '0;
  logic        req_write = 1'b0;
  logic [31:0] cfg_dram_size = 32'h0040_0000;
  logic        cfg_supervisor = 1'b0;
  logic        out_valid;
  logic        out_write;
  logic [2:0]  out_target;
  logic [5:0]  out_am;
  logic [1:0]  out_width;
  logic [31:0] out_vme_addr;
  logic        out_vme_req;
  logic        out_decode_err;

  always #(CLK_PERIOD/2) clk = ~clk;

  vme_map_top u_vme_map_top (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr),
    .req_write(req_write), .cfg_dram_size(cfg_dram_size), .cfg_supervisor(cfg_supervisor),
    .out_valid(out_valid), .out_write(out_write), .out_target(out_target), .out_am(out_am),
    .out_width(out_width), .out_vme_addr(out_vme_addr), .out_vme_req(out_vme_req),
    .out_decode_err(out_decode_err)
  );

  typedef struct {
    string       tag;
    logic        write;
    logic [2:0]  target;
    logic [5:0]  am;
    logic [1:0]  width;
    logic [31:0] vaddr;
    logic        vme_req;
    logic        err;
  } exp_t;

  exp_t exp_q[$];
  int   n_tests = 0;
  int   n_fail  = 0;
  logic [31:0] model_size = 32'h0040_0000;
  logic        model_sup  = 1'b0;

  function automatic exp_t predict(input logic [31:0] a, input logic w, input string tag);
    exp_t e;
    e.tag = tag; e.write = w; e.am = 6'h00; e.width = 2'b00; e.vaddr = 32'h0;
    e.vme_req = 1'b0; e.err = 1'b0;
    if (a < model_size) begin
      e.target = 3'd0;
    end else if (a <= 32'hEFFF_FFFF) begin
      e.target = 3'd2; e.am = model_sup ? 6'h0D : 6'h09; e.width = 2'b10;
      e.vaddr = a; e.vme_req = 1'b1;
    end else if (a[31:24] == 8'hF0) begin
      e.target = 3'd3; e.am = model_sup ? 6'h3D : 6'h39; e.width = 2'b01;
      e.vaddr = {8'h00, a[23:0]}; e.vme_req = 1'b1;
    end else if (a[31:16] == 16'hFFFF) begin
      e.target = 3'd4; e.am = 6'h2D; e.width = 2'b01;
      e.vaddr = {16'h0000, a[15:0]}; e.vme_req = 1'b1;
    end else if (a[31:20] == 12'hFFF) begin
      e.target = 3'd1;
    end else begin
      e.target = 3'd5; e.err = 1'b1;
    end
    return e;
  endfunction

  task automatic check(input string tag, input string what, input logic [31:0] act,
                       input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  task automatic issue(input logic [31:0] a, input logic w, input string tag);
    @(negedge clk);
    req_valid = 1'b1; req_addr = a; req_write = w;
    exp_q.push_back(predict(a, w, tag));
  endtask

  task automatic set_cfg(input logic [31:0] s, input logic sup);
    @(negedge clk);
    req_valid = 1'b0; cfg_dram_size = s; cfg_supervisor = sup;
    @(negedge clk);
    if ((s & (s - 32'd1)) == 32'd0 && s >= 32'h0040_0000 && s <= 32'h1000_0000) model_size = s;
    model_sup = sup;
  endtask

  task automatic idle();
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  // Monitor: compares each registered result with the oldest expectation (R8 latency).
  initial begin
    forever begin
      @(posedge clk);
      #(CLK_PERIOD/4);
      if (rst_n && out_valid) begin
        if (exp_q.size() == 0) begin
          check("R8", "unexpected out_valid", 32'(out_valid), 32'd0);
        end else begin
          exp_t e;
          e = exp_q.pop_front();
          check(e.tag, "target",  32'(out_target),     32'(e.target));
          check(e.tag, "am",      32'(out_am),         32'(e.am));
          check(e.tag, "width",   32'(out_width),      32'(e.width));
          check(e.tag, "vaddr",   out_vme_addr,        e.vaddr);
          check(e.tag, "vme_req", 32'(out_vme_req),    32'(e.vme_req));
          check(e.tag, "err",     32'(out_decode_err), 32'(e.err));
          check("R8",  "write",   32'(out_write),      32'(e.write));
        end
      end else if (rst_n && exp_q.size() != 0) begin
        check("R8", "missing out_valid", 32'(out_valid), 32'd1);
      end
    end
  end

  initial begin
    #(CLK_PERIOD * 200000);
    n_tests++; n_fail++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(posedge clk); #(CLK_PERIOD/4);
    check("R8", "reset out_valid", 32'(out_valid), 32'd0);
    check("R8", "reset vme_req", 32'(out_vme_req), 32'd0);
    check("R8", "reset decode_err", 32'(out_decode_err), 32'd0);

    // Default 4 MB, user mode
    issue(32'h0000_0000, 1'b0, "R1 dram base");
    issue(32'h003F_FFFF, 1'b1, "R1 dram last");
    issue(32'h0040_0000, 1'b0, "R2 a32 first");
    issue(32'h1234_5678, 1'b1, "R2 a32 mid");
    issue(32'hEFFF_FFFF, 1'b0, "R2 a32 last");
    issue(32'hF000_0000, 1'b0, "R3 a24 first");
    issue(32'hF0FF_FFFF, 1'b1, "R3 a24 last");
    issue(32'hF100_0000, 1'b0, "R6 gap first");
    issue(32'hFFEF_FFFF, 1'b1, "R6 gap last");
    issue(32'hFFF0_0000, 1'b0, "R5 io first");
    issue(32'hFFFE_FFFF, 1'b0, "R5 io last");
    issue(32'hFFFF_0000, 1'b1, "R4 a16 first");
    issue(32'hFFFF_FFFF, 1'b0, "R4 a16 last");
    idle();
    idle();

    // Supervisor variants
    set_cfg(32'h0040_0000, 1'b1);
    issue(32'h1000_0000, 1'b0, "R7 a32 sup");
    issue(32'hF0AB_CDEF, 1'b1, "R7 a24 sup");
    issue(32'hFFFF_1234, 1'b0, "R7 a16 unchanged");

    // Legal size change to 16 MB
    set_cfg(32'h0100_0000, 1'b0);
    issue(32'h00FF_FFFF, 1'b0, "R9 16MB dram last");
    issue(32'h0100_0000, 1'b0, "R9 16MB a32 first");

    // Illegal sizes are ignored
    set_cfg(32'h0030_0000, 1'b0);
    issue(32'h00FF_FFFF, 1'b0, "R9 non-pow2 ignored");
    set_cfg(32'h2000_0000, 1'b0);
    issue(32'h0100_0000, 1'b0, "R9 too large ignored");
    set_cfg(32'h0020_0000, 1'b0);
    issue(32'h0030_0000, 1'b0, "R9 too small ignored");

    // Largest legal size
    set_cfg(32'h1000_0000, 1'b0);
    issue(32'h0FFF_FFFF, 1'b1, "R9 256MB dram last");
    issue(32'h1000_0000, 1'b0, "R9 256MB a32 first");

    // Configuration change while requests stay present
    issue(32'h0080_0000, 1'b0, "R10 busy old size");
    cfg_dram_size = 32'h0040_0000;
    cfg_supervisor = 1'b1;
    issue(32'h0080_0000, 1'b1, "R10 busy still old");
    issue(32'h2000_0000, 1'b0, "R10 busy user am");
    set_cfg(32'h0040_0000, 1'b1);
    issue(32'h0080_0000, 1'b0, "R10 after idle new size");
    idle();

    repeat (4) @(negedge clk);
    check("R8", "queue drained", 32'(exp_q.size()), 32'd0);
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule